// File: doc/BRIEF.md
# Match-Triggered Watchdog Timer

This block is a watchdog timer with a small register bus. An up-counter advances once per clock while enabled and is compared on every cycle against a programmable match value. When the count reaches that value while counting is active, the match-control register decides what follows. It can raise an interrupt flag, stop and zero the counter, change a match output pin, or start a reset pulse of programmable width. The reset pulse is either an internal system-reset request alone or that request together with an external reset output.

Software arms the timer by zeroing the counter, choosing the match actions, loading the timeout and setting the enable bit. A sticky status bit records that a watchdog reset pulse was started. That bit and the pulse engine are cleared only by the power-on reset. The ordinary system reset, which the pulse itself may cause, leaves both of them alone. A debug-halt input can freeze the count when software has allowed it to.

Top module: `match_wdog`

## Requirements
- R1: After power-on reset, these registers read 0: control (0x04), counter (0x08), interrupt status (0x00), match control (0x0C) and reset status (0x1C). Pulse width (0x18) reads 0xFFFF and match value (0x10) reads the default timeout count. The irq, sys_rst_req and ext_rst_out outputs are low.
- R2: While control bit 0 is set, the counter at 0x08 increases by one per clock. Writing 0 to control stops it, and the counter then holds its value.
- R3: While control bit 1 is set, the counter is forced to zero and stays there.
- R4: When control bit 2 is set, an active dbg_halt freezes the counter. When bit 2 is clear, dbg_halt has no effect on counting.
- R5: A match happens when the counter equals the match value while counting is active. If match-control bit 0 is set, a match sets interrupt-status bit 0, and the irq output follows that bit. Writing 1 to bit 0 at 0x00 clears it. A match and a clear in the same cycle leave the bit set.
- R6: If match-control bit 2 is set, a match zeroes the counter and clears control bit 0. This takes priority over a control write in the same cycle.
- R7: If match-control bit 3 is set, a match drives sys_rst_req high for (pulse width + 6) clocks, and ext_rst_out stays low.
- R8: If match-control bit 4 is set, a match drives both sys_rst_req and ext_rst_out high for (pulse width + 6) clocks.
- R9: Writing 1 to match-control bit 5 starts the internal-only pulse at once, and writing 1 to bit 6 starts the internal-plus-external pulse. These two bits are not stored and read back 0. A trigger that arrives while a pulse is running is ignored.
- R10: External match control at 0x14 has an action field in bits 5:4 that acts on each match. The codes are 00 keep, 01 drive low, 10 drive high and 11 toggle. Bit 0 holds the match-output state, is writable, and drives match_out.
- R11: Reset-status bit 0 at 0x1C is set when a reset pulse starts. Bus writes do not change it, rst_n does not clear it, and only por_n clears it.
- R12: A running reset pulse keeps its full length even if rst_n is asserted while it runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| por_n | input | 1 | Power-on reset, active low; clears everything |
| rst_n | input | 1 | System reset, active low; spares the status bit and the pulse engine |
| dbg_halt | input | 1 | Debugger halt indication |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Match interrupt flag |
| match_out | output | 1 | Match output state |
| sys_rst_req | output | 1 | Internal system-reset request pulse |
| ext_rst_out | output | 1 | External reset output pulse |

## Verification
The match event and the software write-1-to-clear of the interrupt flag can land on the same clock edge. The bench starts the counter from zero with a match value of 10 and times the clear write to hit exactly the cycle in which the count equals 10. It then expects the flag to read back set, and a later lone clear to drop it. In a second case, a match with counter stop and a control write also meet in one edge, and the stop is expected to win.

// File: rtl/match_wdog_pkg.sv
package match_wdog_pkg;

   typedef enum logic [2:0] {
      IDX_IRQ   = 3'd0,
      IDX_CTRL  = 3'd1,
      IDX_COUNT = 3'd2,
      IDX_MCTL  = 3'd3,
      IDX_MVAL  = 3'd4,
      IDX_OUTC  = 3'd5,
      IDX_WIDTH = 3'd6,
      IDX_STAT  = 3'd7
   } reg_idx_e;

   typedef enum logic [1:0] {
      OUT_KEEP = 2'b00,
      OUT_LOW  = 2'b01,
      OUT_HIGH = 2'b10,
      OUT_FLIP = 2'b11
   } out_act_e;

   typedef struct packed {
      logic halt_ok;
      logic zero;
      logic run;
   } ctrl_t;

   typedef struct packed {
      logic rst_both;
      logic rst_int;
      logic stop;
      logic rsvd;
      logic irq_en;
   } mctl_t;

endpackage

// File: rtl/match_wdog_count.sv
module match_wdog_count #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             zero_req,
   input  logic             halt_ok,
   input  logic             dbg_halt,
   input  logic             stop_on_hit,
   input  logic [CNT_W-1:0] match_val,
   output logic [CNT_W-1:0] count,
   output logic             hit
);

   logic advancing;

   assign advancing = run_en & ~(halt_ok & dbg_halt) & ~zero_req;
   assign hit       = advancing & (count == match_val);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (zero_req) begin
         count <= '0;
      end else if (hit && stop_on_hit) begin
         count <= '0;
      end else if (advancing) begin
         count <= count + 1'b1;
      end
   end

endmodule

// File: rtl/match_wdog_pulse.sv
module match_wdog_pulse #(
   parameter int PW_W  = 16,
   parameter int EXTRA = 6
) (
   input  logic            clk,
   input  logic            por_n,
   input  logic            trig_int,
   input  logic            trig_both,
   input  logic [PW_W-1:0] width,
   output logic            sys_rst_req,
   output logic            ext_rst_out,
   output logic            started
);

   localparam int LEFT_W = $clog2((1 << PW_W) + EXTRA);

   logic              active;
   logic              both_mode;
   logic [LEFT_W-1:0] left;
   logic [LEFT_W-1:0] load_val;

   generate
      if (EXTRA < 1) begin : g_bad_extra
         $error("match_wdog_pulse: EXTRA must be at least 1");
      end
   endgenerate

   assign load_val = LEFT_W'(width) + LEFT_W'(EXTRA - 1);
   assign started  = (trig_int | trig_both) & ~active;

   always_ff @(posedge clk) begin
      if (!por_n) begin
         active    <= 1'b0;
         both_mode <= 1'b0;
         left      <= '0;
      end else if (started) begin
         active    <= 1'b1;
         both_mode <= trig_both;
         left      <= load_val;
      end else if (active) begin
         if (left == '0) begin
            active    <= 1'b0;
            both_mode <= 1'b0;
         end else begin
            left <= left - 1'b1;
         end
      end
   end

   assign sys_rst_req = active;
   assign ext_rst_out = active & both_mode;

endmodule

// File: rtl/match_wdog_regs.sv
module match_wdog_regs
   import match_wdog_pkg::*;
#(
   parameter int              DATA_W    = 32,
   parameter int              ADDR_W    = 5,
   parameter int              CNT_W     = 32,
   parameter int              PW_W      = 16,
   parameter logic [CNT_W-1:0] MATCH_RST = CNT_W'(247000000),
   parameter logic [PW_W-1:0]  WIDTH_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              por_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              we,
   input  logic              hit,
   input  logic [CNT_W-1:0]  count,
   input  logic              pulse_started,
   output ctrl_t             ctrl,
   output mctl_t             mctl,
   output logic [CNT_W-1:0]  match_val,
   output logic [PW_W-1:0]   width,
   output logic [DATA_W-1:0] rdata,
   output logic              irq,
   output logic              match_out,
   output out_act_e          out_act,
   output logic              wd_stat,
   output logic              trig_int,
   output logic              trig_both
);

   logic              in_range;
   reg_idx_e          idx;
   logic [DATA_W-1:0] count_rd;
   logic [DATA_W-1:0] mval_rd;
   logic [DATA_W-1:0] width_rd;
   logic              unused_wdata;

   generate
      if (ADDR_W > 5) begin : g_wide_addr
         assign in_range = (addr[ADDR_W-1:5] == '0);
      end else begin : g_exact_addr
         assign in_range = 1'b1;
      end
      if (CNT_W < DATA_W) begin : g_pad_cnt
         assign count_rd = {{(DATA_W-CNT_W){1'b0}}, count};
         assign mval_rd  = {{(DATA_W-CNT_W){1'b0}}, match_val};
      end else begin : g_full_cnt
         assign count_rd = count;
         assign mval_rd  = match_val;
      end
      if (PW_W < DATA_W) begin : g_pad_pw
         assign width_rd = {{(DATA_W-PW_W){1'b0}}, width};
      end else begin : g_full_pw
         assign width_rd = width;
      end
   endgenerate

   assign idx          = reg_idx_e'(addr[4:2]);
   assign unused_wdata = ^{wdata, addr[1:0]};

   function automatic logic wr_to(input reg_idx_e which);
      return we && in_range && (idx == which);
   endfunction

   assign trig_int  = (hit & mctl.rst_int)  | (wr_to(IDX_MCTL) & wdata[5]);
   assign trig_both = (hit & mctl.rst_both) | (wr_to(IDX_MCTL) & wdata[6]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl      <= '0;
         mctl      <= '0;
         match_val <= MATCH_RST;
         width     <= WIDTH_RST;
         irq       <= 1'b0;
         match_out <= 1'b0;
         out_act   <= OUT_KEEP;
      end else begin
         if (wr_to(IDX_CTRL)) ctrl <= ctrl_t'(wdata[2:0]);
         if (hit && mctl.stop) ctrl.run <= 1'b0;

         if (wr_to(IDX_MCTL)) mctl <= '{rst_both: wdata[4], rst_int: wdata[3],
                                        stop: wdata[2], rsvd: 1'b0, irq_en: wdata[0]};
         if (wr_to(IDX_MVAL))  match_val <= wdata[CNT_W-1:0];
         if (wr_to(IDX_WIDTH)) width     <= wdata[PW_W-1:0];

         if (hit && mctl.irq_en)             irq <= 1'b1;
         else if (wr_to(IDX_IRQ) && wdata[0]) irq <= 1'b0;

         if (wr_to(IDX_OUTC)) begin
            out_act   <= out_act_e'(wdata[5:4]);
            match_out <= wdata[0];
         end
         if (hit) begin
            case (out_act)
               OUT_LOW:  match_out <= 1'b0;
               OUT_HIGH: match_out <= 1'b1;
               OUT_FLIP: match_out <= ~match_out;
               default:  ;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!por_n) wd_stat <= 1'b0;
      else if (pulse_started) wd_stat <= 1'b1;
   end

   always_comb begin
      rdata = '0;
      if (in_range) begin
         case (idx)
            IDX_IRQ:   rdata[0]   = irq;
            IDX_CTRL:  rdata[2:0] = ctrl;
            IDX_COUNT: rdata      = count_rd;
            IDX_MCTL:  rdata[4:0] = mctl;
            IDX_MVAL:  rdata      = mval_rd;
            IDX_OUTC:  begin
               rdata[5:4] = out_act;
               rdata[0]   = match_out;
            end
            IDX_WIDTH: rdata      = width_rd;
            IDX_STAT:  rdata[0]   = wd_stat;
            default:   rdata      = '0;
         endcase
      end
   end

endmodule

// File: rtl/match_wdog.sv
module match_wdog
   import match_wdog_pkg::*;
#(
   parameter int               DATA_W    = 32,
   parameter int               ADDR_W    = 5,
   parameter int               CNT_W     = 32,
   parameter int               PW_W      = 16,
   parameter int               EXTRA     = 6,
   parameter logic [CNT_W-1:0] MATCH_RST = CNT_W'(247000000)
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic              dbg_halt,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   output logic              match_out,
   output logic              sys_rst_req,
   output logic              ext_rst_out
);

   generate
      if (CNT_W > DATA_W || CNT_W < 8) begin : g_bad_cnt
         $error("match_wdog: CNT_W must lie between 8 and DATA_W");
      end
      if (PW_W > DATA_W || PW_W < 4) begin : g_bad_pw
         $error("match_wdog: PW_W must lie between 4 and DATA_W");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("match_wdog: ADDR_W must cover eight word registers");
      end
   endgenerate

   logic             rst_all_n;
   ctrl_t            ctrl;
   mctl_t            mctl;
   out_act_e         out_act;
   logic [CNT_W-1:0] match_val;
   logic [CNT_W-1:0] count;
   logic [PW_W-1:0]  width;
   logic             hit;
   logic             trig_int;
   logic             trig_both;
   logic             pulse_started;
   logic             wd_stat;

   assign rst_all_n = rst_n & por_n;

   match_wdog_count #(.CNT_W(CNT_W)) u_count (
      .clk         (clk),
      .rst_n       (rst_all_n),
      .run_en      (ctrl.run),
      .zero_req    (ctrl.zero),
      .halt_ok     (ctrl.halt_ok),
      .dbg_halt    (dbg_halt),
      .stop_on_hit (mctl.stop),
      .match_val   (match_val),
      .count       (count),
      .hit         (hit)
   );

   match_wdog_regs #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .CNT_W     (CNT_W),
      .PW_W      (PW_W),
      .MATCH_RST (MATCH_RST)
   ) u_regs (
      .clk           (clk),
      .rst_n         (rst_all_n),
      .por_n         (por_n),
      .addr          (bus_addr),
      .wdata         (bus_wdata),
      .we            (bus_we),
      .hit           (hit),
      .count         (count),
      .pulse_started (pulse_started),
      .ctrl          (ctrl),
      .mctl          (mctl),
      .match_val     (match_val),
      .width         (width),
      .rdata         (bus_rdata),
      .irq           (irq),
      .match_out     (match_out),
      .out_act       (out_act),
      .wd_stat       (wd_stat),
      .trig_int      (trig_int),
      .trig_both     (trig_both)
   );

   match_wdog_pulse #(.PW_W(PW_W), .EXTRA(EXTRA)) u_pulse (
      .clk         (clk),
      .por_n       (por_n),
      .trig_int    (trig_int),
      .trig_both   (trig_both),
      .width       (width),
      .sys_rst_req (sys_rst_req),
      .ext_rst_out (ext_rst_out),
      .started     (pulse_started)
   );

endmodule

// File: rtl/match_wdog_chk.sv
module match_wdog_chk
   import match_wdog_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             por_n,
   input logic             rst_n,
   input logic             dbg_halt,
   input ctrl_t            ctrl,
   input mctl_t            mctl,
   input out_act_e         out_act,
   input logic [CNT_W-1:0] count,
   input logic             hit,
   input logic             irq,
   input logic             match_out,
   input logic             sys_rst_req,
   input logic             ext_rst_out,
   input logic             wd_stat
);

   AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      ctrl.zero |=> (count == '0));  // R3

   AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      (ctrl.run && ctrl.halt_ok && dbg_halt && !ctrl.zero) |=> $stable(count));  // R4

   AST_IRQ_ON_MATCH: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      (hit && mctl.irq_en) |=> irq);  // R5

   AST_STOP_ON_MATCH: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      (hit && mctl.stop) |=> (count == '0 && !ctrl.run));  // R6

   AST_EXT_NEEDS_INT: assert property (@(posedge clk) disable iff (!por_n)
      ext_rst_out |-> sys_rst_req);  // R8

   AST_HIGH_ON_MATCH: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      (hit && out_act == OUT_HIGH) |=> match_out);  // R10

   AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!por_n)
      wd_stat |=> wd_stat);  // R11

   AST_PULSE_MARKS: assert property (@(posedge clk) disable iff (!por_n)
      $rose(sys_rst_req) |-> wd_stat);  // R11

endmodule

bind match_wdog match_wdog_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .por_n       (por_n),
   .rst_n       (rst_n),
   .dbg_halt    (dbg_halt),
   .ctrl        (ctrl),
   .mctl        (mctl),
   .out_act     (out_act),
   .count       (count),
   .hit         (hit),
   .irq         (irq),
   .match_out   (match_out),
   .sys_rst_req (sys_rst_req),
   .ext_rst_out (ext_rst_out),
   .wd_stat     (wd_stat)
);

// File: tb/match_wdog_test.sv
`timescale 1ns/1ps
module match_wdog_test;

   localparam logic [4:0] A_IRQ = 5'h00, A_CTRL = 5'h04, A_CNT = 5'h08, A_MCTL = 5'h0C,
                          A_MVAL = 5'h10, A_OUTC = 5'h14, A_PW = 5'h18, A_STAT = 5'h1C;
   localparam logic [31:0] DEF_MATCH = 32'd247000000;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        rst_n = 1'b0;
   logic        dbg_halt = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_rdata;
   logic        irq, match_out, sys_rst_req, ext_rst_out;

   int n_checks = 0;
   int n_errors = 0;

   typedef struct {
      string       tag;
      int          kind;
      logic [31:0] exp;
   } item_t;
   item_t sb_q[$];

   always #2 clk = ~clk;

   match_wdog uut (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .dbg_halt(dbg_halt),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
      .irq(irq), .match_out(match_out), .sys_rst_req(sys_rst_req), .ext_rst_out(ext_rst_out)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // monitor: compares queued expectations one ns after each rising edge
   always begin
      @(posedge clk);
      #1;
      while (sb_q.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it = sb_q.pop_front();
         case (it.kind)
            1:       act = {31'b0, irq};
            2:       act = {31'b0, match_out};
            3:       act = {31'b0, sys_rst_req};
            4:       act = {31'b0, ext_rst_out};
            default: act = bus_rdata;
         endcase
         chk(it.tag, act, it.exp);
      end
   end

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic expect_item(input logic [4:0] a, input int kind,
                              input logic [31:0] exp, input string tag);
      item_t it;
      @(negedge clk);
      bus_addr = a;
      it.tag = tag; it.kind = kind; it.exp = exp;
      sb_q.push_back(it);
      @(posedge clk);
      #2;
   endtask

   task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
      expect_item(a, 0, exp, tag);
   endtask

   task automatic meas(input int n, output int s_cnt, output int e_cnt);
      s_cnt = 0; e_cnt = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (sys_rst_req) s_cnt++;
         if (ext_rst_out) e_cnt++;
      end
   endtask

   initial begin
      #(4 * 150000);
      n_errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      int s_cnt, e_cnt;
      repeat (4) @(negedge clk);
      por_n = 1'b1; rst_n = 1'b1;

      // R1 reset state
      rd(A_CTRL, 32'h0, "R1 ctrl");
      rd(A_CNT,  32'h0, "R1 counter");
      rd(A_IRQ,  32'h0, "R1 irq status");
      rd(A_MCTL, 32'h0, "R1 match ctrl");
      rd(A_PW,   32'hFFFF, "R1 pulse width");
      rd(A_MVAL, DEF_MATCH, "R1 match value");
      rd(A_STAT, 32'h0, "R1 status");
      expect_item(A_CTRL, 1, 0, "R1 irq pin");
      expect_item(A_CTRL, 3, 0, "R1 sys_rst_req");
      expect_item(A_CTRL, 4, 0, "R1 ext_rst_out");

      // R2 counting and stop
      wr(A_CTRL, 32'h1);
      repeat (10) @(negedge clk);
      wr(A_CTRL, 32'h0);
      rd(A_CNT, 32'd12, "R2 count after run");
      repeat (5) @(negedge clk);
      rd(A_CNT, 32'd12, "R2 count held after stop");

      // R3 zeroing
      wr(A_CTRL, 32'h2);
      rd(A_CNT, 32'd0, "R3 counter zeroed");

      // R4 debug halt
      dbg_halt = 1'b1;
      wr(A_CTRL, 32'h5);
      repeat (5) @(negedge clk);
      wr(A_CTRL, 32'h0);
      rd(A_CNT, 32'd0, "R4 frozen while halted");
      wr(A_CTRL, 32'h1);
      repeat (4) @(negedge clk);
      wr(A_CTRL, 32'h0);
      rd(A_CNT, 32'd6, "R4 halt ignored without permit");
      dbg_halt = 1'b0;

      // R5 R6 R10 match with irq, stop and output high
      wr(A_MVAL, 32'd20);
      wr(A_OUTC, 32'h20);
      wr(A_MCTL, 32'h5);
      wr(A_CTRL, 32'h2);
      wr(A_CTRL, 32'h1);
      repeat (40) @(negedge clk);
      rd(A_IRQ, 32'h1, "R5 flag set on match");
      expect_item(A_IRQ, 1, 1, "R5 irq pin");
      rd(A_CTRL, 32'h0, "R6 run bit cleared");
      rd(A_CNT, 32'h0, "R6 counter zeroed");
      rd(A_OUTC, 32'h21, "R10 output driven high");
      expect_item(A_IRQ, 2, 1, "R10 match_out pin");
      wr(A_IRQ, 32'h1);
      rd(A_IRQ, 32'h0, "R5 write one clears");
      wr(A_OUTC, 32'h31);
      wr(A_CTRL, 32'h1);
      repeat (40) @(negedge clk);
      rd(A_OUTC, 32'h30, "R10 output toggled");

      // R5 match and clear in the same edge
      wr(A_MCTL, 32'h1);
      wr(A_OUTC, 32'h0);
      wr(A_MVAL, 32'd10);
      wr(A_CTRL, 32'h2);
      wr(A_IRQ, 32'h1);
      wr(A_CTRL, 32'h1);
      repeat (9) @(negedge clk);
      wr(A_IRQ, 32'h1);
      rd(A_IRQ, 32'h1, "R5 set beats same-cycle clear");
      wr(A_CTRL, 32'h0);
      wr(A_IRQ, 32'h1);
      rd(A_IRQ, 32'h0, "R5 later clear");

      // R6 stop beats a control write in the same edge
      wr(A_MCTL, 32'h4);
      wr(A_CTRL, 32'h2);
      wr(A_CTRL, 32'h1);
      repeat (9) @(negedge clk);
      wr(A_CTRL, 32'h1);
      rd(A_CTRL, 32'h0, "R6 stop wins over write");

      // R7 internal-only pulse
      wr(A_PW, 32'd4);
      wr(A_MVAL, 32'd5);
      wr(A_MCTL, 32'h0C);
      wr(A_CTRL, 32'h2);
      fork
         meas(40, s_cnt, e_cnt);
         wr(A_CTRL, 32'h1);
      join
      chk("R7 sys pulse width", s_cnt, 10);
      chk("R7 ext stays low", e_cnt, 0);

      // R9 forced pulse, retrigger ignored
      fork
         meas(40, s_cnt, e_cnt);
         begin
            wr(A_MCTL, 32'h40);
            repeat (3) @(negedge clk);
            wr(A_MCTL, 32'h40);
         end
      join
      chk("R9 forced sys width", s_cnt, 10);
      chk("R9 forced ext width", e_cnt, 10);
      rd(A_MCTL, 32'h0, "R9 force bits read zero");

      // R8 R11 R12 both-type pulse with system reset during it
      wr(A_PW, 32'd4);
      wr(A_MVAL, 32'd5);
      wr(A_MCTL, 32'h14);
      wr(A_CTRL, 32'h2);
      fork
         meas(40, s_cnt, e_cnt);
         begin
            wr(A_CTRL, 32'h1);
            repeat (8) @(negedge clk);
            rst_n = 1'b0;
            repeat (2) @(negedge clk);
            rst_n = 1'b1;
         end
      join
      chk("R8 sys width", s_cnt, 10);
      chk("R12 ext width survives rst_n", e_cnt, 10);
      rd(A_STAT, 32'h1, "R11 status survives rst_n");
      wr(A_STAT, 32'h0);
      rd(A_STAT, 32'h1, "R11 status ignores write");
      rd(A_PW, 32'hFFFF, "R1 width back to default");

      @(negedge clk);
      por_n = 1'b0;
      repeat (2) @(negedge clk);
      por_n = 1'b1;
      rd(A_STAT, 32'h0, "R11 cleared by por_n");
      rd(A_MVAL, DEF_MATCH, "R1 match default after por");

      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule